// File: doc/BRIEF.md
# Dual Data Pointer Register Unit

This unit keeps two 16-bit data pointers for an 8-bit microcontroller core. Exactly one pointer is active at any time. A select bit in a byte-wide auxiliary control register decides which one. The core reaches the pointers through its special-function-register (SFR) bus. The low-byte and high-byte addresses are the same for both pointers, so the select bit steers each access to one physical pair or the other.

The active pointer is always presented on a 16-bit output that feeds the external data memory address path. A single-cycle increment request advances the active pointer by one as a full 16-bit value. The inactive pointer is untouched by this increment. Software can therefore keep two independent address streams, for example a source and a destination, and flip between them with one control write.

Top module: `dptr_bank_unit`

## Requirements
- R1: After a synchronous reset, both pointers hold 0000h and the select bit is 0. `dptr_out` reads 0000h, and reads of 82h, 83h and A2h all return 00h.
- R2: With the select bit at 0, a write to 82h loads the low byte of pointer 0 and a write to 83h loads its high byte. Reads of these addresses return what was written.
- R3: With the select bit at 1, writes to 82h and 83h land in pointer 1 and leave pointer 0 unchanged. This is checked by switching back and reading pointer 0.
- R4: A write to the auxiliary register at A2h sets the select bit from data bit 0. Writes to bits 7..1 are ignored, and a read of A2h returns those bits as 0.
- R5: `dptr_out` equals the pointer chosen by the select bit, starting from the first cycle after the write that changes it.
- R6: An increment request adds 1 to the active pointer as a 16-bit value. The low byte carries into the high byte, FFFFh wraps to 0000h, and the inactive pointer keeps its value.
- R7: If an SFR write to 82h or 83h and an increment request arrive in the same cycle, the written byte is loaded and the increment is dropped. The other byte of that pointer keeps its value.
- R8: If a write to A2h and an increment request arrive in the same cycle, the increment applies to the pointer that was selected before the write.
- R9: Writes to any other SFR address change no pointer and do not change the select bit. Reads of other addresses, and the read data whenever `sfr_rd` is low, are 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | SFR address of the current access |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_rd | input | 1 | SFR read strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data, combinational, 00h when no register matches |
| inc_req | input | 1 | Increment the active pointer at this edge |
| dptr_out | output | 16 | Active pointer for external data addressing |

## Verification
An increment request can coincide in one cycle with an SFR write to a pointer byte, and with a write that flips the select bit. The bench sweeps both collisions on each pointer by asserting `inc_req` together with `sfr_wr`. It drives pointer-byte values that would show a carry if the increment were wrongly applied. The outcome is judged against a bench model that gives the byte write priority and applies an increment to the previously selected pointer. Both pointers are then read back so that a misrouted update shows up.

// File: rtl/dptr_pkg.sv
`timescale 1ns/1ps
package dptr_pkg;
  // Which register a given SFR address reaches
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_LO   = 2'd1,
    TGT_HI   = 2'd2,
    TGT_AUX  = 2'd3
  } sfr_tgt_e;
endpackage

// File: rtl/dptr_sfr_decode.sv
`timescale 1ns/1ps
module dptr_sfr_decode #(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  LO_ADDR  = 8'h82,
  parameter logic [7:0]  HI_ADDR  = 8'h83,
  parameter logic [7:0]  AUX_ADDR = 8'hA2
) (
  input  logic [ADDR_W-1:0] addr,
  output dptr_pkg::sfr_tgt_e tgt
);
  always_comb begin
    if (addr == ADDR_W'(LO_ADDR))       tgt = dptr_pkg::TGT_LO;
    else if (addr == ADDR_W'(HI_ADDR))  tgt = dptr_pkg::TGT_HI;
    else if (addr == ADDR_W'(AUX_ADDR)) tgt = dptr_pkg::TGT_AUX;
    else                                tgt = dptr_pkg::TGT_NONE;
  end
endmodule

// File: rtl/dptr_pair.sv
`timescale 1ns/1ps
module dptr_pair #(
  parameter int DATA_W = 8,
  localparam int PTR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              inc,
  input  logic [DATA_W-1:0] wdata,
  output logic [PTR_W-1:0]  ptr
);
  // A byte write has priority over an increment in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (wr_lo) begin
      ptr[DATA_W-1:0] <= wdata;
    end else if (wr_hi) begin
      ptr[PTR_W-1:DATA_W] <= wdata;
    end else if (inc) begin
      ptr <= ptr + PTR_W'(1);
    end
  end
endmodule

// File: rtl/dptr_sel_reg.sv
`timescale 1ns/1ps
module dptr_sel_reg #(
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [SEL_W-1:0] wdata,
  output logic [SEL_W-1:0] sel
);
  always_ff @(posedge clk) begin
    if (rst)     sel <= '0;
    else if (wr) sel <= wdata;
  end
endmodule

// File: rtl/dptr_bank_unit.sv
`timescale 1ns/1ps
module dptr_bank_unit #(
  parameter int          DATA_W    = 8,
  parameter int          ADDR_W    = 8,
  parameter int          NUM_PAIRS = 2,
  parameter logic [7:0]  LO_ADDR   = 8'h82,
  parameter logic [7:0]  HI_ADDR   = 8'h83,
  parameter logic [7:0]  AUX_ADDR  = 8'hA2,
  localparam int PTR_W = 2 * DATA_W,
  localparam int SEL_W = $clog2(NUM_PAIRS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic              sfr_rd,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] sfr_rdata,
  input  logic              inc_req,
  output logic [PTR_W-1:0]  dptr_out
);
  dptr_pkg::sfr_tgt_e tgt;
  logic               wr_lo, wr_hi, wr_aux;
  logic [SEL_W-1:0]   sel;
  logic [PTR_W-1:0]   pair_ptr [NUM_PAIRS];

  dptr_sfr_decode #(
    .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR), .AUX_ADDR(AUX_ADDR)
  ) u_dec (
    .addr(sfr_addr),
    .tgt (tgt)
  );

  always_comb begin
    wr_lo  = sfr_wr && (tgt == dptr_pkg::TGT_LO);
    wr_hi  = sfr_wr && (tgt == dptr_pkg::TGT_HI);
    wr_aux = sfr_wr && (tgt == dptr_pkg::TGT_AUX);
  end

  // Reserved upper bits of the control byte are never stored
  dptr_sel_reg #(.SEL_W(SEL_W)) u_sel (
    .clk  (clk),
    .rst  (rst),
    .wr   (wr_aux),
    .wdata(sfr_wdata[SEL_W-1:0]),
    .sel  (sel)
  );

  // Each pair only sees strobes while it is the selected one; the
  // select used here is the value before any same-cycle control write.
  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    logic hit;
    assign hit = (sel == SEL_W'(i));
    dptr_pair #(.DATA_W(DATA_W)) u_pair (
      .clk  (clk),
      .rst  (rst),
      .wr_lo(wr_lo && hit),
      .wr_hi(wr_hi && hit),
      .inc  (inc_req && hit),
      .wdata(sfr_wdata),
      .ptr  (pair_ptr[i])
    );
  end

  assign dptr_out = pair_ptr[sel];

  always_comb begin
    sfr_rdata = '0;
    if (sfr_rd) begin
      case (tgt)
        dptr_pkg::TGT_LO:  sfr_rdata = dptr_out[DATA_W-1:0];
        dptr_pkg::TGT_HI:  sfr_rdata = dptr_out[PTR_W-1:DATA_W];
        dptr_pkg::TGT_AUX: sfr_rdata[SEL_W-1:0] = sel;
        default:           sfr_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dptr_bank_chk.sv
`timescale 1ns/1ps
module dptr_bank_chk #(
  parameter int          DATA_W   = 8,
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  LO_ADDR  = 8'h82,
  parameter logic [7:0]  HI_ADDR  = 8'h83,
  parameter logic [7:0]  AUX_ADDR = 8'hA2,
  localparam int PTR_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic              sfr_wr,
  input logic              sfr_rd,
  input logic [DATA_W-1:0] sfr_wdata,
  input logic [DATA_W-1:0] sfr_rdata,
  input logic              inc_req,
  input logic [PTR_W-1:0]  dptr_out
);
  logic known_addr;
  assign known_addr = (sfr_addr == ADDR_W'(LO_ADDR)) || (sfr_addr == ADDR_W'(HI_ADDR)) ||
                      (sfr_addr == ADDR_W'(AUX_ADDR));

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> dptr_out == '0); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!sfr_wr && !inc_req) |=> $stable(dptr_out)); // R5

  AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc_req && !sfr_wr) |=> dptr_out == $past(dptr_out) + PTR_W'(1)); // R6

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    (inc_req && sfr_wr && sfr_addr == ADDR_W'(LO_ADDR)) |=>
      (dptr_out[DATA_W-1:0] == $past(sfr_wdata) &&
       dptr_out[PTR_W-1:DATA_W] == $past(dptr_out[PTR_W-1:DATA_W]))); // R7

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sfr_rd && sfr_addr == ADDR_W'(AUX_ADDR)) |-> sfr_rdata[DATA_W-1:1] == '0); // R4

  AST_OTHER_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!sfr_rd || !known_addr) |-> sfr_rdata == '0); // R9
endmodule

bind dptr_bank_unit dptr_bank_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR), .AUX_ADDR(AUX_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd),
  .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .inc_req(inc_req), .dptr_out(dptr_out)
);

// File: tb/sim_dptr_bank_unit.sv
`timescale 1ns/1ps
module sim_dptr_bank_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  sfr_addr = 8'h00;
  logic        sfr_wr = 1'b0;
  logic        sfr_rd = 1'b0;
  logic [7:0]  sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic        inc_req = 1'b0;
  logic [15:0] dptr_out;

  int checks = 0;
  int errors = 0;
  logic [15:0] mp [2];
  logic        msel;

  always #2.5 clk = ~clk;   // 200 MHz

  dptr_bank_unit u0 (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .inc_req(inc_req), .dptr_out(dptr_out)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One clocked operation; the model applies the requirement rules
  task automatic op(logic [7:0] a, logic w, logic [7:0] d, logic inc, string tag);
    logic s;
    @(negedge clk);
    sfr_addr = a; sfr_wr = w; sfr_wdata = d; inc_req = inc;
    @(posedge clk);
    #1;
    sfr_wr = 1'b0; inc_req = 1'b0;
    s = msel;
    if (w && a == 8'h82)      mp[s][7:0]  = d;
    else if (w && a == 8'h83) mp[s][15:8] = d;
    else if (inc)             mp[s] = mp[s] + 16'd1;
    if (w && a == 8'hA2) msel = d[0];
    chk(tag, dptr_out, mp[msel]);
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    sfr_addr = a; sfr_rd = 1'b1;
    #1;
    chk(tag, {8'h00, sfr_rdata}, {8'h00, exp});
    sfr_rd = 1'b0;
  endtask

  task automatic read_both(string tag);
    logic keep;
    keep = msel;
    for (int p = 0; p < 2; p++) begin
      op(8'hA2, 1'b1, 8'(p), 1'b0, tag);
      rd(8'h82, mp[p][7:0], tag);
      rd(8'h83, mp[p][15:8], tag);
    end
    op(8'hA2, 1'b1, {7'd0, keep}, 1'b0, tag);
  endtask

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    mp[0] = 16'h0000; mp[1] = 16'h0000; msel = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    chk("R1 dptr_out", dptr_out, 16'h0000);
    rd(8'h82, 8'h00, "R1 low");
    rd(8'h83, 8'h00, "R1 high");
    rd(8'hA2, 8'h00, "R1 aux");
    read_both("R1 both pairs");

    // R2: full byte sweep on pointer 0
    for (int v = 0; v < 256; v++) begin
      op(8'h82, 1'b1, 8'(v), 1'b0, "R2 low write");
      rd(8'h82, 8'(v), "R2 low read");
      op(8'h83, 1'b1, ~8'(v), 1'b0, "R2 high write");
      rd(8'h83, ~8'(v), "R2 high read");
    end

    // R3: same addresses reach pointer 1 with select set
    op(8'hA2, 1'b1, 8'h01, 1'b0, "R3 select");
    for (int v = 0; v < 256; v++) begin
      op(8'h82, 1'b1, 8'(v) ^ 8'h5A, 1'b0, "R3 low write");
      op(8'h83, 1'b1, 8'(v) + 8'h33, 1'b0, "R3 high write");
      rd(8'h82, 8'(v) ^ 8'h5A, "R3 low read");
    end
    read_both("R3 pair isolation");

    // R4 and R5: every control byte value
    for (int v = 0; v < 256; v++) begin
      op(8'hA2, 1'b1, 8'(v), 1'b0, "R5 output follows select");
      rd(8'hA2, {7'd0, 1'(v)}, "R4 reserved bits read zero");
    end

    // R6: carry from low into high for every high byte value, pointer 0
    op(8'hA2, 1'b1, 8'h00, 1'b0, "R6 select");
    for (int h = 0; h < 256; h++) begin
      op(8'h83, 1'b1, 8'(h), 1'b0, "R6 load high");
      op(8'h82, 1'b1, 8'hFF, 1'b0, "R6 load low");
      op(8'h00, 1'b0, 8'h00, 1'b1, "R6 carry increment");
    end
    op(8'h82, 1'b1, 8'hFF, 1'b0, "R6 load low");
    op(8'h83, 1'b1, 8'hFF, 1'b0, "R6 load high");
    op(8'h00, 1'b0, 8'h00, 1'b1, "R6 wrap to zero");
    op(8'hA2, 1'b1, 8'h01, 1'b0, "R6 select");
    for (int k = 0; k < 300; k++) op(8'h00, 1'b0, 8'h00, 1'b1, "R6 run on pointer 1");
    read_both("R6 inactive unchanged");

    // R7: byte write collides with increment
    for (int p = 0; p < 2; p++) begin
      op(8'hA2, 1'b1, 8'(p), 1'b0, "R7 select");
      for (int v = 0; v < 256; v += 17) begin
        op(8'h82, 1'b1, 8'hFF, 1'b0, "R7 preload low");
        op(8'h83, 1'b1, 8'(v), 1'b0, "R7 preload high");
        op(8'h82, 1'b1, 8'(v) | 8'h0F, 1'b1, "R7 low write wins");
        op(8'h83, 1'b1, ~8'(v), 1'b1, "R7 high write wins");
      end
    end
    read_both("R7 both pairs");

    // R8: select write collides with increment
    for (int k = 0; k < 8; k++) begin
      op(8'hA2, 1'b1, {7'h55, ~msel}, 1'b1, "R8 increment uses old select");
      read_both("R8 both pairs");
    end

    // R9: unrelated SFR addresses
    for (int a = 0; a < 256; a++) begin
      if (a != 8'h82 && a != 8'h83 && a != 8'hA2) begin
        op(8'(a), 1'b1, 8'hFF, 1'b0, "R9 foreign write");
        if ((a % 16) == 1) rd(8'(a), 8'h00, "R9 foreign read");
      end
    end
    read_both("R9 pairs intact");
    @(negedge clk);
    sfr_addr = 8'h82; sfr_rd = 1'b0;
    #1;
    chk("R9 no read strobe", {8'h00, sfr_rdata}, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule